// File: doc/BRIEF.md
# Loop Load Divergence Profiler

This block learns, while a kernel runs, how the loads inside each loop spread across cache lines. It uses the first warps that enter a loop to do this, then keeps the result for the warps that come later. Each load-issue event carries a warp number, a loop identifier, the program counter of the load, an active-lane mask and one cache-line address per lane. The block merges the line addresses of the active lanes into a count of distinct lines. A load that touches one line is recorded as non-diverged, and a load that touches several lines is recorded as diverged. This result is stored once for each static load in each loop. It is not rewritten when later warps run the same load.

The block also decides whether a loop has locality. For each warp it keeps a short history of the lines the warp touched in its previous loop iteration. It then watches the L1 hit reports. A hit by that warp on one of those lines marks the loop as having locality. A scheduler reads the results through a combinational query port. For a given loop and load it returns the stored classification, the loop's locality flag and a footprint estimate in cache lines. The footprint is zero unless the loop has locality. The table holds a fixed number of loops and is refilled in least-recently-used order. A clear input wipes every profile when a new kernel starts.

Top module: `loop_div_profiler`

## Requirements
- R1: A load event with a non-zero mask records the number of distinct line addresses among the active lanes. Inactive lanes are ignored. The count is read back on `q_lines`.
- R2: `q_diverged` is 1 when the recorded count is above one and 0 when it is exactly one. A load event with an all-zero mask records nothing, touches no loop and does not enter the reuse history.
- R3: Only the first execution of a given load in a given loop is recorded. Later events for the same loop and program counter, from any warp, leave the stored count unchanged.
- R4: Classification is kept per program counter within each loop. The same program counter in two different loops holds two independent records.
- R5: The locality flag of a loop is set by a hit report for that loop whose line matches one of the lines recorded for the same warp in its previous iteration. Only the lowest active lane's line of each load is recorded, up to HIST lines per iteration. An iteration boundary for a warp moves its current lines to the previous set. A hit on a line of the current iteration, or on a line from another warp, does not set the flag.
- R6: `q_footprint` equals the sum of the recorded line counts of all valid loads of the queried loop when its locality flag is set. Otherwise it is 0.
- R7: Each loop holds at most LOADS (default 8) load records. Load events with further new program counters in a full loop are not recorded.
- R8: The table holds LOOPS (default 8) loops. A load event for an unknown loop when all entries are in use replaces the least recently used loop, meaning the one whose last non-empty load event is oldest. Hit reports do not count as use. The evicted loop's records and flag are gone, and the new entry starts without locality.
- R9: A one-cycle `clear` removes all loop entries and all per-warp line histories.
- R10: After reset no loop or load is found, and `q_lines`, `q_locality` and `q_footprint` are 0.
- R11: Queries are combinational on registered state. An event is visible on the query outputs from the cycle after the clock edge that takes it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous wipe of all profiles (new kernel) |
| ld_valid | input | 1 | Load-issue event strobe |
| ld_warp | input | WARP_W | Issuing warp |
| ld_loop | input | LOOP_ID_W | Loop identifier of the load |
| ld_pc | input | PC_W | Program counter of the load |
| ld_mask | input | LANES | Active-lane mask |
| ld_lines | input | LANES*LINE_W | Line address per lane, lane 0 in the low bits |
| hit_valid | input | 1 | L1 hit report strobe |
| hit_warp | input | WARP_W | Warp that hit |
| hit_loop | input | LOOP_ID_W | Loop the hitting load belongs to |
| hit_line | input | LINE_W | Line address that hit |
| iter_valid | input | 1 | Loop iteration boundary strobe |
| iter_warp | input | WARP_W | Warp that crossed the boundary |
| q_loop | input | LOOP_ID_W | Query loop identifier |
| q_pc | input | PC_W | Query program counter |
| q_loop_found | output | 1 | Queried loop is in the table |
| q_load_found | output | 1 | Queried load has a record |
| q_diverged | output | 1 | Queried load is diverged |
| q_lines | output | CNT_W | Recorded distinct-line count of the queried load |
| q_locality | output | 1 | Queried loop has locality |
| q_footprint | output | FP_W | Footprint of the queried loop in lines, 0 without locality |

## Verification
The bench uses masks whose inactive lanes point at distinct lines, and a dense group of lanes that all fall inside one line. A coalescer that counted masked lanes, or that counted lanes instead of lines, would report the wrong count. It re-issues an already profiled load with a scattered pattern, which catches a table that rewrites records instead of freezing them. It also reuses one program counter in a second loop to catch records shared across loops. Locality is probed with a hit on a line of the current iteration, a hit from a warp with no history, and a hit on an unrelated line before the real match. A tracker that compared against the wrong iteration or the wrong warp would set the flag early. The bench then fills a loop past its slot count and fills the loop table while making the oldest loop recent again. A table that evicted by allocation order, or that let a ninth load in, shows it at the query port. A clear followed by a hit on a line from before the clear catches histories that survive a new kernel.

// File: rtl/ldp_pkg.sv
package ldp_pkg;

  // A load counts as diverged when it generated more than one line.
  function automatic logic is_diverged(input int unsigned line_cnt);
    return line_cnt > 32'd1;
  endfunction

  // A loop contributes its footprint only when locality was seen.
  function automatic int unsigned gated_footprint(input logic has_loc,
                                                  input int unsigned total);
    return has_loc ? total : 32'd0;
  endfunction

endpackage

// File: rtl/ldp_coalesce.sv
module ldp_coalesce #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LINE_W-1:0] lines,
  output logic [CNT_W-1:0]        uniq_cnt,
  output logic [LINE_W-1:0]       leader_line,
  output logic                    any_active
);

  logic [LANES-1:0] first_seen;

  // A lane counts when it is active and no lower active lane shares its line.
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic dup;
    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < gi; j++) begin
        if (mask[j] && (lines[j*LINE_W +: LINE_W] == lines[gi*LINE_W +: LINE_W]))
          dup = 1'b1;
      end
    end
    assign first_seen[gi] = mask[gi] && !dup;
  end

  assign uniq_cnt   = CNT_W'($countones(first_seen));
  assign any_active = |mask;

  always_comb begin
    leader_line = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) leader_line = lines[i*LINE_W +: LINE_W];
    end
  end

endmodule

// File: rtl/ldp_reuse_hist.sv
module ldp_reuse_hist #(
  parameter int WARPS  = 8,
  parameter int HIST   = 4,
  parameter int LINE_W = 25,
  localparam int WARP_W = $clog2(WARPS),
  localparam int HCNT_W = $clog2(HIST + 1),
  localparam int HIDX_W = $clog2(HIST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rec_valid,
  input  logic [WARP_W-1:0] rec_warp,
  input  logic [LINE_W-1:0] rec_line,
  input  logic              iter_valid,
  input  logic [WARP_W-1:0] iter_warp,
  input  logic [WARP_W-1:0] probe_warp,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_match
);

  logic [WARPS-1:0] warp_match;

  for (genvar w = 0; w < WARPS; w++) begin : g_warp
    logic [LINE_W-1:0] cur_l  [HIST];
    logic [LINE_W-1:0] prev_l [HIST];
    logic [HCNT_W-1:0] cur_n;
    logic [HCNT_W-1:0] prev_n;
    logic              do_rec;
    logic              do_iter;

    assign do_rec  = rec_valid && (rec_warp == WARP_W'(w));
    assign do_iter = iter_valid && (iter_warp == WARP_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_n  <= '0;
        prev_n <= '0;
        for (int k = 0; k < HIST; k++) begin
          cur_l[k]  <= '0;
          prev_l[k] <= '0;
        end
      end else if (clear) begin
        cur_n  <= '0;
        prev_n <= '0;
      end else if (do_iter) begin
        // Boundary first: a load in the same cycle opens the new iteration.
        for (int k = 0; k < HIST; k++) prev_l[k] <= cur_l[k];
        prev_n <= cur_n;
        if (do_rec) begin
          cur_l[0] <= rec_line;
          cur_n    <= HCNT_W'(1);
        end else begin
          cur_n <= '0;
        end
      end else if (do_rec && (cur_n < HCNT_W'(HIST))) begin
        cur_l[cur_n[HIDX_W-1:0]] <= rec_line;
        cur_n <= cur_n + HCNT_W'(1);
      end
    end

    always_comb begin
      warp_match[w] = 1'b0;
      for (int k = 0; k < HIST; k++) begin
        if ((HCNT_W'(k) < prev_n) && (prev_l[k] == probe_line))
          warp_match[w] = 1'b1;
      end
    end

    // R5: the history never holds more lines than it has room for.
    assert_hist_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_n <= HCNT_W'(HIST)) && (prev_n <= HCNT_W'(HIST)));
  end

  assign probe_match = warp_match[probe_warp];

endmodule

// File: rtl/ldp_profile_tbl.sv
module ldp_profile_tbl
  import ldp_pkg::*;
#(
  parameter int LOOPS     = 8,
  parameter int LOADS     = 8,
  parameter int LOOP_ID_W = 4,
  parameter int PC_W      = 16,
  parameter int CNT_W     = 6,
  localparam int IDX_W  = $clog2(LOOPS),
  localparam int SLOT_W = $clog2(LOADS),
  localparam int FP_W   = CNT_W + $clog2(LOADS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 ld_valid,
  input  logic [LOOP_ID_W-1:0] ld_loop,
  input  logic [PC_W-1:0]      ld_pc,
  input  logic [CNT_W-1:0]     ld_lines,
  input  logic                 hit_set,
  input  logic [LOOP_ID_W-1:0] hit_loop,
  input  logic [LOOP_ID_W-1:0] q_loop,
  input  logic [PC_W-1:0]      q_pc,
  output logic                 q_loop_found,
  output logic                 q_load_found,
  output logic                 q_diverged,
  output logic [CNT_W-1:0]     q_lines,
  output logic                 q_locality,
  output logic [FP_W-1:0]      q_footprint
);

  logic [LOOPS-1:0]     lp_v;
  logic [LOOPS-1:0]     lp_loc;
  logic [LOOP_ID_W-1:0] lp_tag  [LOOPS];
  logic [IDX_W-1:0]     lp_age  [LOOPS];
  logic [LOADS-1:0]     sl_v    [LOOPS];
  logic [PC_W-1:0]      sl_pc   [LOOPS][LOADS];
  logic [CNT_W-1:0]     sl_lines[LOOPS][LOADS];

  // Event-side lookups
  logic              ld_found, pc_found, free_found, vic_found, hit_found;
  logic [IDX_W-1:0]  ld_idx, victim, hit_idx, touch_idx;
  logic [SLOT_W-1:0] free_slot;
  logic              alloc, write_slot, set_loc;
  logic [LOOPS-1:0]  evict_vec;

  always_comb begin
    ld_found = 1'b0;
    ld_idx   = '0;
    for (int i = 0; i < LOOPS; i++) begin
      if (!ld_found && lp_v[i] && (lp_tag[i] == ld_loop)) begin
        ld_found = 1'b1;
        ld_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pc_found   = 1'b0;
    free_found = 1'b0;
    free_slot  = '0;
    for (int s = 0; s < LOADS; s++) begin
      if (sl_v[ld_idx][s] && (sl_pc[ld_idx][s] == ld_pc)) pc_found = 1'b1;
      if (!free_found && !sl_v[ld_idx][s]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    vic_found = 1'b0;
    victim    = '0;
    for (int i = 0; i < LOOPS; i++) begin
      if (!vic_found && !lp_v[i]) begin
        vic_found = 1'b1;
        victim    = IDX_W'(i);
      end
    end
    if (!vic_found) begin
      for (int i = 0; i < LOOPS; i++) begin
        if (lp_age[i] == IDX_W'(LOOPS - 1)) victim = IDX_W'(i);
      end
    end
  end

  always_comb begin
    hit_found = 1'b0;
    hit_idx   = '0;
    for (int i = 0; i < LOOPS; i++) begin
      if (!hit_found && lp_v[i] && (lp_tag[i] == hit_loop)) begin
        hit_found = 1'b1;
        hit_idx   = IDX_W'(i);
      end
    end
  end

  assign alloc      = ld_valid && !ld_found;
  assign touch_idx  = alloc ? victim : ld_idx;
  assign write_slot = ld_valid && ld_found && !pc_found && free_found;
  assign set_loc    = hit_set && hit_found && !(alloc && (hit_idx == victim));

  for (genvar gi = 0; gi < LOOPS; gi++) begin : g_evict
    assign evict_vec[gi] = alloc && (victim == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_v   <= '0;
      lp_loc <= '0;
      for (int i = 0; i < LOOPS; i++) begin
        lp_tag[i] <= '0;
        lp_age[i] <= IDX_W'(i);
        sl_v[i]   <= '0;
        for (int s = 0; s < LOADS; s++) begin
          sl_pc[i][s]    <= '0;
          sl_lines[i][s] <= '0;
        end
      end
    end else if (clear) begin
      lp_v   <= '0;
      lp_loc <= '0;
      for (int i = 0; i < LOOPS; i++) begin
        lp_age[i] <= IDX_W'(i);
        sl_v[i]   <= '0;
      end
    end else begin
      // Recency: the touched entry becomes youngest, younger ones age by one.
      if (ld_valid) begin
        for (int i = 0; i < LOOPS; i++) begin
          if (IDX_W'(i) == touch_idx)
            lp_age[i] <= '0;
          else if (lp_age[i] < lp_age[touch_idx])
            lp_age[i] <= lp_age[i] + IDX_W'(1);
        end
      end
      if (set_loc) lp_loc[hit_idx] <= 1'b1;
      if (alloc) begin
        lp_v[victim]           <= 1'b1;
        lp_loc[victim]         <= 1'b0;
        lp_tag[victim]         <= ld_loop;
        sl_v[victim]           <= LOADS'(1);
        sl_pc[victim][0]       <= ld_pc;
        sl_lines[victim][0]    <= ld_lines;
      end
      if (write_slot) begin
        sl_v[ld_idx][free_slot]     <= 1'b1;
        sl_pc[ld_idx][free_slot]    <= ld_pc;
        sl_lines[ld_idx][free_slot] <= ld_lines;
      end
    end
  end

  // Query side
  logic              q_hit_pc;
  logic [IDX_W-1:0]  q_idx;
  logic [CNT_W-1:0]  q_cnt;
  logic [FP_W-1:0]   fp_sum;

  always_comb begin
    q_loop_found = 1'b0;
    q_idx        = '0;
    for (int i = 0; i < LOOPS; i++) begin
      if (!q_loop_found && lp_v[i] && (lp_tag[i] == q_loop)) begin
        q_loop_found = 1'b1;
        q_idx        = IDX_W'(i);
      end
    end
  end

  always_comb begin
    q_hit_pc = 1'b0;
    q_cnt    = '0;
    fp_sum   = '0;
    for (int s = 0; s < LOADS; s++) begin
      if (sl_v[q_idx][s]) begin
        fp_sum = fp_sum + FP_W'(sl_lines[q_idx][s]);
        if (!q_hit_pc && (sl_pc[q_idx][s] == q_pc)) begin
          q_hit_pc = 1'b1;
          q_cnt    = sl_lines[q_idx][s];
        end
      end
    end
  end

  assign q_load_found = q_loop_found && q_hit_pc;
  assign q_lines      = q_load_found ? q_cnt : '0;
  assign q_diverged   = q_load_found && is_diverged(32'(q_cnt));
  assign q_locality   = q_loop_found && lp_loc[q_idx];
  assign q_footprint  = q_loop_found ?
                        FP_W'(gated_footprint(lp_loc[q_idx], 32'(fp_sum))) : '0;

  // R8: the recency ages always form a permutation of 0..LOOPS-1.
  logic [LOOPS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < LOOPS; i++) age_seen[lp_age[i]] = 1'b1;
  end

  assert_age_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    age_seen == {LOOPS{1'b1}});

  // R9: a clear leaves no loop entry behind.
  assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lp_v == '0));

  for (genvar gi = 0; gi < LOOPS; gi++) begin : g_chk
    // R5: locality only rises after a matching hit report.
    assert_loc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lp_loc[gi]) |-> $past(hit_set));
    for (genvar gs = 0; gs < LOADS; gs++) begin : g_slot
      // R3: a valid record is frozen until its loop is evicted or cleared.
      assert_slot_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_v[gi][gs] && !clear && !evict_vec[gi]) |=>
          ($stable(sl_lines[gi][gs]) && $stable(sl_pc[gi][gs]) && sl_v[gi][gs]));
    end
  end

endmodule

// File: rtl/loop_div_profiler.sv
module loop_div_profiler #(
  parameter int LANES     = 32,
  parameter int LINE_W    = 25,
  parameter int LOOPS     = 8,
  parameter int LOADS     = 8,
  parameter int WARPS     = 8,
  parameter int HIST      = 4,
  parameter int LOOP_ID_W = 4,
  parameter int PC_W      = 16,
  localparam int WARP_W = $clog2(WARPS),
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int FP_W   = CNT_W + $clog2(LOADS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    ld_valid,
  input  logic [WARP_W-1:0]       ld_warp,
  input  logic [LOOP_ID_W-1:0]    ld_loop,
  input  logic [PC_W-1:0]         ld_pc,
  input  logic [LANES-1:0]        ld_mask,
  input  logic [LANES*LINE_W-1:0] ld_lines,
  input  logic                    hit_valid,
  input  logic [WARP_W-1:0]       hit_warp,
  input  logic [LOOP_ID_W-1:0]    hit_loop,
  input  logic [LINE_W-1:0]       hit_line,
  input  logic                    iter_valid,
  input  logic [WARP_W-1:0]       iter_warp,
  input  logic [LOOP_ID_W-1:0]    q_loop,
  input  logic [PC_W-1:0]         q_pc,
  output logic                    q_loop_found,
  output logic                    q_load_found,
  output logic                    q_diverged,
  output logic [CNT_W-1:0]        q_lines,
  output logic                    q_locality,
  output logic [FP_W-1:0]         q_footprint
);

  logic [CNT_W-1:0]  co_count;
  logic [LINE_W-1:0] co_leader;
  logic              co_any;
  logic              ld_take;
  logic              reuse_match;
  logic              hit_set;

  ldp_coalesce #(.LANES(LANES), .LINE_W(LINE_W)) u_coalesce (
    .mask        (ld_mask),
    .lines       (ld_lines),
    .uniq_cnt    (co_count),
    .leader_line (co_leader),
    .any_active  (co_any)
  );

  // Events with no active lane are dropped before any state sees them.
  assign ld_take = ld_valid && co_any;

  ldp_reuse_hist #(.WARPS(WARPS), .HIST(HIST), .LINE_W(LINE_W)) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .rec_valid   (ld_take),
    .rec_warp    (ld_warp),
    .rec_line    (co_leader),
    .iter_valid  (iter_valid),
    .iter_warp   (iter_warp),
    .probe_warp  (hit_warp),
    .probe_line  (hit_line),
    .probe_match (reuse_match)
  );

  assign hit_set = hit_valid && reuse_match;

  ldp_profile_tbl #(
    .LOOPS(LOOPS), .LOADS(LOADS), .LOOP_ID_W(LOOP_ID_W),
    .PC_W(PC_W), .CNT_W(CNT_W)
  ) u_tbl (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .ld_valid     (ld_take),
    .ld_loop      (ld_loop),
    .ld_pc        (ld_pc),
    .ld_lines     (co_count),
    .hit_set      (hit_set),
    .hit_loop     (hit_loop),
    .q_loop       (q_loop),
    .q_pc         (q_pc),
    .q_loop_found (q_loop_found),
    .q_load_found (q_load_found),
    .q_diverged   (q_diverged),
    .q_lines      (q_lines),
    .q_locality   (q_locality),
    .q_footprint  (q_footprint)
  );

  // R1: the distinct-line count is zero exactly when no lane is active,
  // and never exceeds the number of active lanes.
  assert_count_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (((co_count == '0) == (ld_mask == '0)) &&
                  (32'(co_count) <= $countones(ld_mask))));

  // R2: a masked-off event never matches a loop for the table.
  assert_empty_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_mask == '0)) |-> !ld_take);

endmodule

// File: tb/loop_div_profiler_tb.sv
module loop_div_profiler_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int LINE_W = 25;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    clear = 1'b0;
  logic                    ld_valid = 1'b0;
  logic [2:0]              ld_warp = '0;
  logic [3:0]              ld_loop = '0;
  logic [15:0]             ld_pc = '0;
  logic [LANES-1:0]        ld_mask = '0;
  logic [LANES*LINE_W-1:0] ld_lines = '0;
  logic                    hit_valid = 1'b0;
  logic [2:0]              hit_warp = '0;
  logic [3:0]              hit_loop = '0;
  logic [LINE_W-1:0]       hit_line = '0;
  logic                    iter_valid = 1'b0;
  logic [2:0]              iter_warp = '0;
  logic [3:0]              q_loop = '0;
  logic [15:0]             q_pc = '0;
  logic                    q_loop_found, q_load_found, q_diverged, q_locality;
  logic [5:0]              q_lines;
  logic [9:0]              q_footprint;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_div_profiler u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .ld_valid(ld_valid), .ld_warp(ld_warp), .ld_loop(ld_loop), .ld_pc(ld_pc),
    .ld_mask(ld_mask), .ld_lines(ld_lines),
    .hit_valid(hit_valid), .hit_warp(hit_warp), .hit_loop(hit_loop), .hit_line(hit_line),
    .iter_valid(iter_valid), .iter_warp(iter_warp),
    .q_loop(q_loop), .q_pc(q_pc),
    .q_loop_found(q_loop_found), .q_load_found(q_load_found), .q_diverged(q_diverged),
    .q_lines(q_lines), .q_locality(q_locality), .q_footprint(q_footprint)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Byte address of each lane is base + lane*stride; lines are 128 bytes.
  task automatic set_lanes(input logic [31:0] base, input logic [31:0] stride);
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] a;
      a = base + 32'(i) * stride;
      ld_lines[i*LINE_W +: LINE_W] = a[31:7];
    end
  endtask

  task automatic issue(input int warp, input int loop, input int pc,
                       input logic [31:0] mask, input logic [31:0] base,
                       input logic [31:0] stride);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_warp  = 3'(warp);
    ld_loop  = 4'(loop);
    ld_pc    = 16'(pc);
    ld_mask  = mask;
    set_lanes(base, stride);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic hit(input int warp, input int loop, input int line);
    @(negedge clk);
    hit_valid = 1'b1;
    hit_warp  = 3'(warp);
    hit_loop  = 4'(loop);
    hit_line  = LINE_W'(line);
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic iter(input int warp);
    @(negedge clk);
    iter_valid = 1'b1;
    iter_warp  = 3'(warp);
    @(negedge clk);
    iter_valid = 1'b0;
  endtask

  task automatic query(input int loop, input int pc);
    q_loop = 4'(loop);
    q_pc   = 16'(pc);
    #1;
  endtask

  task automatic t_reset;
    query(1, 'h40);
    check("R10 loop found after reset", int'(q_loop_found), 0);
    check("R10 lines after reset", int'(q_lines), 0);
    check("R10 footprint after reset", int'(q_footprint), 0);
  endtask

  task automatic t_classify;
    // R11: before the capturing edge nothing is visible.
    @(negedge clk);
    ld_valid = 1'b1; ld_warp = 3'd0; ld_loop = 4'd1; ld_pc = 16'h40;
    ld_mask = '1; set_lanes(32'h1000, 32'd0);
    query(1, 'h40);
    check("R11 not visible before edge", int'(q_load_found), 0);
    @(negedge clk);
    ld_valid = 1'b0;
    query(1, 'h40);
    check("R11 visible after edge", int'(q_load_found), 1);
    check("R1 single line count", int'(q_lines), 1);
    check("R2 single line non-diverged", int'(q_diverged), 0);
    // 32 lanes, 32-byte stride: 1024 bytes across 8 lines.
    issue(0, 1, 'h44, 32'hFFFF_FFFF, 32'h2000, 32'd32);
    query(1, 'h44);
    check("R1 strided count", int'(q_lines), 8);
    check("R2 strided diverged", int'(q_diverged), 1);
    // Only 4 low lanes active, each on its own line; masked lanes ignored.
    issue(0, 1, 'h48, 32'h0000_000F, 32'h4000, 32'd128);
    query(1, 'h48);
    check("R1 masked lanes ignored", int'(q_lines), 4);
    // Upper 16 lanes, 4-byte stride from 0x8040: all inside one line.
    issue(0, 1, 'h4C, 32'hFFFF_0000, 32'h8000, 32'd4);
    query(1, 'h4C);
    check("R1 upper lanes one line", int'(q_lines), 1);
    check("R2 upper lanes non-diverged", int'(q_diverged), 0);
  endtask

  task automatic t_frozen_and_per_loop;
    issue(1, 1, 'h40, 32'hFFFF_FFFF, 32'h3000, 32'd128);
    query(1, 'h40);
    check("R3 later warp does not reprofile", int'(q_lines), 1);
    issue(1, 2, 'h40, 32'hFFFF_FFFF, 32'h3000, 32'd128);
    query(2, 'h40);
    check("R4 same pc other loop own record", int'(q_lines), 32);
    query(1, 'h40);
    check("R4 first loop record untouched", int'(q_lines), 1);
    issue(1, 2, 'h50, 32'h0, 32'h5000, 32'd128);
    query(2, 'h50);
    check("R2 empty mask not recorded", int'(q_load_found), 0);
  endtask

  task automatic t_locality;
    query(1, 'h40);
    check("R6 no footprint without locality", int'(q_footprint), 0);
    hit(0, 1, 'h20);                 // line of the current iteration
    query(1, 'h40);
    check("R5 current-iteration hit ignored", int'(q_locality), 0);
    iter(0);
    hit(1, 1, 'h20);                 // warp 1 has no previous iteration
    query(1, 'h40);
    check("R5 other warp hit ignored", int'(q_locality), 0);
    hit(0, 1, 'h999);
    query(1, 'h40);
    check("R5 unrelated line ignored", int'(q_locality), 0);
    hit(0, 1, 'h40);                 // leader line of pc 0x44
    query(1, 'h40);
    check("R5 previous-iteration hit sets locality", int'(q_locality), 1);
    check("R6 footprint sums records", int'(q_footprint), 14);
    query(2, 'h40);
    check("R6 loop without locality has 0", int'(q_footprint), 0);
  endtask

  task automatic t_slots;
    for (int k = 0; k < 9; k++) issue(2, 3, 'h100 + 4*k, 32'hFFFF_FFFF, 32'h0, 32'd0);
    query(3, 'h100 + 4*7);
    check("R7 eighth load recorded", int'(q_load_found), 1);
    query(3, 'h100 + 4*8);
    check("R7 ninth load dropped", int'(q_load_found), 0);
  endtask

  task automatic t_lru;
    for (int l = 4; l <= 8; l++) issue(3, l, 'h0, 32'h1, 32'h0, 32'd0);
    issue(3, 1, 'h40, 32'h1, 32'h0, 32'd0);   // loop 1 becomes most recent
    issue(3, 9, 'h0, 32'h1, 32'h0, 32'd0);    // evicts loop 2
    query(2, 'h40);
    check("R8 least recent loop evicted", int'(q_loop_found), 0);
    query(1, 'h40);
    check("R8 touched loop kept", int'(q_loop_found), 1);
    check("R8 kept loop keeps locality", int'(q_locality), 1);
    query(9, 'h0);
    check("R8 new loop present", int'(q_loop_found), 1);
    check("R8 new loop starts without locality", int'(q_locality), 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    query(1, 'h40);
    check("R9 clear empties table", int'(q_loop_found), 0);
    check("R9 clear zero footprint", int'(q_footprint), 0);
    issue(0, 1, 'h40, 32'hFFFF_FFFF, 32'h1000, 32'd0);
    hit(0, 1, 'h40);                 // was in warp 0's history before clear
    query(1, 'h40);
    check("R9 clear wipes histories", int'(q_locality), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_frozen_and_per_loop();
    t_locality();
    t_slots();
    t_lru();
    t_clear();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule